// File: doc/BRIEF.md
# DMA Channel Mask and Transfer-Width Register Bank

This block holds the per-channel request masks and transfer-width selections of a four-channel DMA controller. The host reaches both registers through one shared write address. Bit 3 of the written byte decides which register a write updates: set, it is a command to set or clear one mask bit; clear, it loads the four width bits. The width path is only reachable while 16-bit mode is enabled. A second command select writes all four mask bits at once and leaves the widths alone.

The channel logic sees the width bits directly. It also sees a request-enable vector, which is each incoming request line gated by its own mask bit. A read of the shared address returns the masks in the low nibble. The high nibble holds either the widths or all ones, depending on 16-bit mode. Reset and master clear both set every mask and width bit, so no hardware request gets through until software clears a mask.

Top module: `dma_mask_width_bank`

## Requirements
- R1: Asynchronous reset (rst_n low) and synchronous master clear (mclr high at a clock edge) set all four mask bits and all four width bits to 1. Master clear wins over any write in the same cycle.
- R2: A shared-address write (sel_shared) with wr_data[3]=1 changes only the mask bit of the channel given by wr_data[1:0]. That bit is set when wr_data[2]=1 and cleared when wr_data[2]=0. The other mask bits, the width bits and wr_data[7:4] have no effect.
- R3: With mode16_en=1, a shared-address write with wr_data[3]=0 loads width bit i from wr_data[4+i] for i=0..3. wr_data[2:0] are ignored and the mask bits stay unchanged.
- R4: With mode16_en=0, every shared-address write is a single-mask command as in R2, whatever the value of wr_data[3]. The width bits are not changed.
- R5: A write-all-mask write (sel_allmask) loads mask bit i from wr_data[i] for i=0..3. wr_data[7:4] are ignored and the width bits are not changed.
- R6: While rd_en=1, rd_data[3:0] shows the mask bits of channels 0..3. rd_data[7:4] shows the width bits of channels 0..3 when mode16_en=1 and reads 4'hF when mode16_en=0. While rd_en=0, rd_data is 8'h00.
- R7: req_en[i] equals dreq[i] AND NOT mask[i]. It is combinational, with no clock delay.
- R8: A write takes effect at the rising edge where wr_en=1 is sampled, and the mask and width outputs change just after that edge. With wr_en=0, the select and data inputs change nothing. A read reflects the register values as they stand in the read cycle.
- R9: If sel_shared and sel_allmask are both high in one write, only the shared-address command is carried out.
- R10: width_8b[i]=0 means channel i does 16-bit transfers, and width_8b[i]=1 means it does 8-bit transfers. The outputs mask_o and width_8b carry the stored bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mclr | input | 1 | Synchronous master clear |
| mode16_en | input | 1 | 16-bit transfer mode enable |
| wr_en | input | 1 | Host write strobe |
| sel_shared | input | 1 | Write targets the shared mask/width address |
| sel_allmask | input | 1 | Write is the write-all-mask command |
| wr_data | input | 8 | Host write byte |
| rd_en | input | 1 | Host read strobe for the shared address |
| rd_data | output | 8 | Combined read-back byte |
| dreq | input | 4 | Per-channel hardware request lines |
| req_en | output | 4 | Requests that pass their mask |
| mask_o | output | 4 | Stored mask bits, 1 = masked |
| width_8b | output | 4 | Stored width bits, 1 = 8-bit, 0 = 16-bit |

## Verification
There is one register stage between a write and its effect. The mask and width values move just after the edge that samples the write strobe. The bench drives each write on a falling edge and holds it through the next rising edge. It compares the stored values on the following falling edge, and it also confirms the old values half a cycle before that edge. Read-back and request gating are combinational. They are checked in the same cycle as their inputs, shortly after the inputs are driven and away from any clock edge.

// File: rtl/dmw_pkg.sv
package dmw_pkg;
    localparam int CH_NUM     = 4;
    localparam int SEL_W      = $clog2(CH_NUM);
    // Field positions of the command byte; these are decoded behaviour.
    localparam int SETCLR_BIT = SEL_W;
    localparam int STEER_BIT  = SEL_W + 1;
    localparam int WIDTH_LSB  = STEER_BIT + 1;
    localparam int BYTE_W     = WIDTH_LSB + CH_NUM;

    typedef logic [CH_NUM-1:0] ch_vec_t;

    typedef struct packed {
        ch_vec_t mask;
        ch_vec_t width;
    } bank_t;

    localparam bank_t BANK_CLEAR = '{mask: '1, width: '1};
endpackage

// File: rtl/dmw_write_decode.sv
module dmw_write_decode
    import dmw_pkg::*;
(
    input  bank_t             cur,
    input  logic              wr_en,
    input  logic              sel_shared,
    input  logic              sel_allmask,
    input  logic              mode16_en,
    input  logic [BYTE_W-1:0] wr_data,
    output bank_t             nxt
);
    logic              single_cmd;
    logic              width_cmd;
    logic              all_cmd;
    logic [SEL_W-1:0]  ch_sel;
    logic              set_val;
    ch_vec_t           single_mask;

    assign ch_sel  = wr_data[SEL_W-1:0];
    assign set_val = wr_data[SETCLR_BIT];

    always_comb begin
        single_cmd = 1'b0;
        width_cmd  = 1'b0;
        all_cmd    = 1'b0;
        if (wr_en) begin
            if (sel_shared) begin
                if (mode16_en && !wr_data[STEER_BIT]) begin
                    width_cmd = 1'b1;
                end else begin
                    single_cmd = 1'b1;
                end
            end else if (sel_allmask) begin
                all_cmd = 1'b1;
            end
        end
    end

    for (genvar g = 0; g < CH_NUM; g++) begin : g_chan
        assign single_mask[g] = (ch_sel == SEL_W'(g)) ? set_val : cur.mask[g];
    end

    always_comb begin
        nxt = cur;
        if (single_cmd) begin
            nxt.mask = single_mask;
        end
        if (all_cmd) begin
            nxt.mask = wr_data[CH_NUM-1:0];
        end
        if (width_cmd) begin
            nxt.width = wr_data[WIDTH_LSB +: CH_NUM];
        end
    end

    AST_ONE_CMD: assert final ($onehot0({single_cmd, width_cmd, all_cmd})); // R9
endmodule

// File: rtl/dmw_readback.sv
module dmw_readback
    import dmw_pkg::*;
(
    input  bank_t             cur,
    input  logic              mode16_en,
    input  logic              rd_en,
    output logic [BYTE_W-1:0] rd_data
);
    localparam int UPPER_W = BYTE_W - CH_NUM;

    logic [UPPER_W-1:0] upper;

    always_comb begin
        upper = '1;
        if (mode16_en) begin
            upper = UPPER_W'(cur.width);
        end
        rd_data = '0;
        if (rd_en) begin
            rd_data = {upper, cur.mask};
        end
    end
endmodule

// File: rtl/dmw_req_gate.sv
module dmw_req_gate
    import dmw_pkg::*;
(
    input  ch_vec_t dreq,
    input  ch_vec_t mask,
    output ch_vec_t req_en
);
    for (genvar g = 0; g < CH_NUM; g++) begin : g_gate
        assign req_en[g] = dreq[g] & ~mask[g];
    end
endmodule

// File: rtl/dma_mask_width_bank.sv
module dma_mask_width_bank
    import dmw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mclr,
    input  logic              mode16_en,
    input  logic              wr_en,
    input  logic              sel_shared,
    input  logic              sel_allmask,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [BYTE_W-1:0] rd_data,
    input  logic [CH_NUM-1:0] dreq,
    output logic [CH_NUM-1:0] req_en,
    output logic [CH_NUM-1:0] mask_o,
    output logic [CH_NUM-1:0] width_8b
);
    bank_t bank_q;
    bank_t bank_d;
    bank_t bank_wr;

    dmw_write_decode i_decode (
        .cur         (bank_q),
        .wr_en       (wr_en),
        .sel_shared  (sel_shared),
        .sel_allmask (sel_allmask),
        .mode16_en   (mode16_en),
        .wr_data     (wr_data),
        .nxt         (bank_wr)
    );

    always_comb begin
        bank_d = bank_wr;
        if (mclr) begin
            bank_d = BANK_CLEAR;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= BANK_CLEAR;
        end else begin
            bank_q <= bank_d;
        end
    end

    dmw_readback i_readback (
        .cur       (bank_q),
        .mode16_en (mode16_en),
        .rd_en     (rd_en),
        .rd_data   (rd_data)
    );

    dmw_req_gate i_gate (
        .dreq   (dreq),
        .mask   (bank_q.mask),
        .req_en (req_en)
    );

    assign mask_o   = bank_q.mask;
    assign width_8b = bank_q.width;

    AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        mclr |=> (mask_o == '1) && (width_8b == '1)); // R1

    AST_SINGLE_TOUCH: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel_shared && !mclr && (!mode16_en || wr_data[STEER_BIT]))
        |=> ($countones(mask_o ^ $past(mask_o)) <= 1) && $stable(width_8b)); // R2

    AST_WIDTH_MASK_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel_shared && !mclr && mode16_en && !wr_data[STEER_BIT])
        |=> $stable(mask_o)); // R3

    AST_ALLMASK_WIDTH_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !sel_shared && sel_allmask && !mclr) |=> $stable(width_8b)); // R5

    AST_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !mclr) |=> $stable(mask_o) && $stable(width_8b)); // R8

    AST_RD_UPPER_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !mode16_en) |-> (rd_data[BYTE_W-1:CH_NUM] == '1)); // R6

    AST_REQ_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_en & mask_o) == '0); // R7
endmodule

// File: tb/test_dma_mask_width_bank.sv
module test_dma_mask_width_bank;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mclr = 1'b0;
    logic       mode16_en = 1'b0;
    logic       wr_en = 1'b0;
    logic       sel_shared = 1'b0;
    logic       sel_allmask = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic [3:0] dreq = 4'h0;
    logic [3:0] req_en;
    logic [3:0] mask_o;
    logic [3:0] width_8b;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    dma_mask_width_bank i_dma_mask_width_bank (
        .clk (clk), .rst_n (rst_n), .mclr (mclr), .mode16_en (mode16_en),
        .wr_en (wr_en), .sel_shared (sel_shared), .sel_allmask (sel_allmask),
        .wr_data (wr_data), .rd_en (rd_en), .rd_data (rd_data),
        .dreq (dreq), .req_en (req_en), .mask_o (mask_o), .width_8b (width_8b)
    );

    // {mode16, sel_shared, sel_allmask, data, expected mask, expected width}
    localparam int NV = 9;
    localparam logic [18:0] VEC [NV] = '{
        {1'b0, 1'b1, 1'b0, 8'h00, 4'hE, 4'hF},
        {1'b1, 1'b1, 1'b0, 8'h09, 4'hC, 4'hF},
        {1'b1, 1'b1, 1'b0, 8'h50, 4'hC, 4'h5},
        {1'b1, 1'b0, 1'b1, 8'hA3, 4'h3, 4'h5},
        {1'b1, 1'b1, 1'b0, 8'hFE, 4'h7, 4'h5},
        {1'b0, 1'b1, 1'b0, 8'h02, 4'h3, 4'h5},
        {1'b1, 1'b1, 1'b1, 8'h0F, 4'hB, 4'h5},
        {1'b1, 1'b0, 1'b1, 8'h00, 4'h0, 4'h5},
        {1'b1, 1'b1, 1'b0, 8'hF0, 4'h0, 4'hF}
    };
    string vtag [NV] = '{"R4", "R2", "R3", "R5", "R2", "R4", "R9", "R5", "R3"};

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic write_cmd(input logic m16, input logic sh, input logic al, input logic [7:0] d);
        @(negedge clk);
        mode16_en = m16; sel_shared = sh; sel_allmask = al; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; sel_shared = 1'b0; sel_allmask = 1'b0;
    endtask

    task automatic read_check(input string tag, input logic [7:0] exp);
        rd_en = 1'b1;
        #0.5;
        check(tag, rd_data, exp);
        rd_en = 1'b0;
        #0.5;
    endtask

    initial begin : watchdog
        #100000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R1 reset state, R10 width encoding
        check("R1 mask at reset", {4'h0, mask_o}, 8'h0F);
        check("R10 width at reset", {4'h0, width_8b}, 8'h0F);
        rst_n = 1'b1;
        @(negedge clk);
        mode16_en = 1'b1;
        read_check("R6 read after reset mode16", 8'hFF);
        dreq = 4'hF; #0.5;
        check("R7 all masked after reset", {4'h0, req_en}, 8'h00);
        dreq = 4'h0;

        for (int i = 0; i < NV; i++) begin
            logic [18:0] v;
            v = VEC[i];
            write_cmd(v[18], v[17], v[16], v[15:8]);
            check({vtag[i], " mask"}, {4'h0, mask_o}, {4'h0, v[7:4]});
            check({vtag[i], " width"}, {4'h0, width_8b}, {4'h0, v[3:0]});
            read_check({vtag[i], " readback"}, {v[18] ? v[3:0] : 4'hF, v[7:4]});
        end

        // mask now 0, width F
        mode16_en = 1'b0;
        read_check("R6 upper ones with mode16 off", 8'hF0);
        rd_en = 1'b0; #0.5;
        check("R6 idle read is zero", rd_data, 8'h00);

        // R7 gating
        write_cmd(1'b1, 1'b0, 1'b1, 8'h05);
        dreq = 4'hF; #0.5;
        check("R7 gated requests", {4'h0, req_en}, 8'h0A);
        dreq = 4'h6; #0.5;
        check("R7 gated requests pattern 2", {4'h0, req_en}, 8'h02);
        dreq = 4'h0;

        // R8: selects and data without wr_en do nothing
        @(negedge clk);
        mode16_en = 1'b1; sel_shared = 1'b1; sel_allmask = 1'b1; wr_data = 8'h30;
        @(negedge clk);
        @(negedge clk);
        sel_shared = 1'b0; sel_allmask = 1'b0;
        check("R8 no strobe keeps mask", {4'h0, mask_o}, 8'h05);
        check("R8 no strobe keeps width", {4'h0, width_8b}, 8'h0F);

        // R8: value unchanged before the edge, changed after
        @(negedge clk);
        sel_allmask = 1'b1; wr_data = 8'h0C; wr_en = 1'b1;
        #1;
        check("R8 before edge", {4'h0, mask_o}, 8'h05);
        @(negedge clk);
        wr_en = 1'b0; sel_allmask = 1'b0;
        check("R8 after edge", {4'h0, mask_o}, 8'h0C);

        // R1: master clear beats a simultaneous write
        write_cmd(1'b1, 1'b1, 1'b0, 8'h00);
        check("R3 width cleared to 16-bit", {4'h0, width_8b}, 8'h00);
        @(negedge clk);
        sel_allmask = 1'b1; wr_data = 8'h00; wr_en = 1'b1; mclr = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; sel_allmask = 1'b0; mclr = 1'b0;
        check("R1 mclr mask", {4'h0, mask_o}, 8'h0F);
        check("R1 mclr width", {4'h0, width_8b}, 8'h0F);

        // R1: asynchronous reset mid-run
        write_cmd(1'b1, 1'b0, 1'b1, 8'h00);
        #1 rst_n = 1'b0;
        #0.5;
        check("R1 async reset mask", {4'h0, mask_o}, 8'h0F);
        rst_n = 1'b1;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule